// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM of 65,536 words by 16 bits. Each request on the internal side carries an address, a write flag, write data and a per-byte lane mask. The block turns it into a timed sequence on the memory pins: chip select, write strobe, output enable, two active-low byte-lane enables, the address, and a data bus split into output value, output enable and input value for a tri-state pad.

The memory has no clock, so every phase is counted in cycles of the controller clock. The number of strobe cycles is derived at elaboration time from the access time and the clock period. Between requests the chip select is released, which lets the memory drop into its low-power state.

The request side is valid/ready. `req_ready` is high only while the sequencer is idle. A request whose `req_valid` is held high while `req_ready` is low waits, with its fields stable, and is taken exactly once, at the first rising edge where both are high. Reads are answered by a single-cycle `rsp_valid` pulse. The response path has no back-pressure, so the consumer must take it in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever no request is in progress, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are high, `mem_dq_oe` is low and `req_ready` is high.
- R2: A write holds `mem_ce_n` low for one setup cycle with `mem_we_n` high. It then holds `mem_we_n` low for the strobe phase, then gives one hold cycle with `mem_we_n` high, then releases `mem_ce_n`. `mem_we_n` is never low while `mem_ce_n` is high.
- R3: During any access, `mem_be_n[i]` equals the inverse of `req_mask[i]` captured at acceptance. Bit 0 is the lower lane (data bits 7:0) and bit 1 is the upper lane (bits 15:8). A write with mask 00 leaves the memory contents unchanged.
- R4: A read holds `mem_ce_n` low with `mem_oe_n` high for one setup cycle. It then holds `mem_oe_n` low for the sample phase. `mem_we_n` stays high for the whole read.
- R5: `mem_dq_oe` is high only during the write strobe phase, and there `mem_dq_o` carries the accepted write data.
- R6: The controller never drives the bus while the memory drives it, that is, while chip select and output enable are low, the write strobe is high and some lane is enabled. `mem_dq_oe` is low in the cycle before `mem_oe_n` falls.
- R7: A read is answered by `rsp_valid` high for exactly one cycle, in the cycle after the last sample cycle. Lanes whose mask bit was 1 carry the memory data and lanes whose mask bit was 0 read as zero. Writes produce no response.
- R8: A write stores only the lanes whose mask bit is 1 and leaves the other lane of that word as it was.
- R9: `req_ready` is low from the cycle after acceptance until the access completes. A request held valid while `req_ready` is low is accepted exactly once.
- R10: The strobe phase of a write and the sample phase of a read each last max(1, ceil(ACCESS_PS / CLK_PERIOD_PS)) cycles.
- R11: `mem_addr` stays stable in every cycle in which `mem_ce_n` was also low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane mask, bit i enables bits 8i+7:8i |
| rsp_valid | output | 1 | Read data valid, single-cycle pulse |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low, bit 0 lower |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Value for the data pad driver |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_i | input | DATA_W | Value seen on the data pad |

## Verification
The hardest situation to reach from the ports is a write followed directly by a read of the same word. There the pad driver must already be off before the memory starts to drive, and the read must return the freshly merged lanes. The stimulus issues each request as soon as the previous one has been accepted, so the next request waits with valid high through the whole busy period. It also runs a computed sequence of mixed partial-lane writes and reads over a small address set, so that lane merges and turnarounds come up often. A pin-level memory model in the bench drives the bus only under the tri-state conditions and flags every cycle in which both sides drive.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WR_SETUP,
    SEQ_WR_STROBE,
    SEQ_WR_HOLD,
    SEQ_RD_SETUP,
    SEQ_RD_SAMPLE
  } seq_state_e;

  // Strobe length in cycles: ceiling of access over period, at least one.
  function automatic int unsigned strobe_cycles(input int unsigned access_ps,
                                                input int unsigned period_ps);
    int unsigned q;
    q = (access_ps + period_ps - 1) / period_ps;
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int unsigned CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              timer_done,
  output logic              timer_load,
  output logic              cap_en,
  output logic [LANES-1:0]  lane_sel,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              accept;

  assign accept = req_valid && (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:      if (req_valid) state_d = req_write ? SEQ_WR_SETUP : SEQ_RD_SETUP;
      SEQ_WR_SETUP:  state_d = SEQ_WR_STROBE;
      SEQ_WR_STROBE: if (timer_done) state_d = SEQ_WR_HOLD;
      SEQ_WR_HOLD:   state_d = SEQ_IDLE;
      SEQ_RD_SETUP:  state_d = SEQ_RD_SAMPLE;
      SEQ_RD_SAMPLE: if (timer_done) state_d = SEQ_IDLE;
      default:       state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
    end
  end

  // Both setup states always move to a counted phase next.
  assign timer_load = (state_q == SEQ_WR_SETUP) || (state_q == SEQ_RD_SETUP);
  assign cap_en     = (state_q == SEQ_RD_SAMPLE) && timer_done;
  assign lane_sel   = mask_q;

  assign req_ready = (state_q == SEQ_IDLE);
  assign mem_ce_n  = (state_q == SEQ_IDLE);
  assign mem_we_n  = (state_q != SEQ_WR_STROBE);
  assign mem_oe_n  = (state_q != SEQ_RD_SAMPLE);
  assign mem_be_n  = (state_q == SEQ_IDLE) ? {LANES{1'b1}} : ~mask_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = (state_q == SEQ_WR_STROBE);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [LANES-1:0]  lane_sel,
  input  logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] masked;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign masked[l*8 +: 8] = lane_sel[l] ? din[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= masked;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned ACCESS_PS     = 10000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);
  localparam int unsigned LANES       = DATA_W / 8;
  localparam int unsigned WAIT_CYCLES = strobe_cycles(ACCESS_PS, CLK_PERIOD_PS);

  logic             timer_load;
  logic             timer_done;
  logic             cap_en;
  logic [LANES-1:0] lane_sel;

  sram_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (timer_load),
    .done (timer_done)
  );

  sram_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .timer_done(timer_done),
    .timer_load(timer_load),
    .cap_en    (cap_en),
    .lane_sel  (lane_sel),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .lane_sel (lane_sel),
    .din      (mem_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  // R1: an idle sequencer leaves every memory control deasserted
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

  // R2: write strobe only inside chip select
  a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R2: strobe falls only after a cycle with chip select already low
  a_r2_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  // R4: output enable and write strobe never low together
  a_r4_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R5: pad driver enabled only in the strobe phase
  a_r5_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  // R6: driver already off in the cycle before output enable falls
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(mem_oe_n)) |-> !$past(mem_dq_oe));

  // R7: response is a single-cycle pulse
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11: address held while chip select stays low
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_be_n (mem_be_n),
  .mem_addr (mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;
  localparam int CLK_PS = 5000;
  localparam int ACC_PS = 10000;
  localparam int RAW_W  = (ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WAIT = (RAW_W < 1) ? 1 : RAW_W;

  localparam int M_IDLE = 0, M_WS = 1, M_WP = 2, M_WH = 3, M_RS = 4, M_RA = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(16), .DATA_W(16), .CLK_PERIOD_PS(CLK_PS), .ACCESS_PS(ACC_PS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Pin-level memory and request-level shadow, kept apart.
  logic [15:0] pin_mem [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] pin_rd(input logic [15:0] a);
    return pin_mem.exists(int'(a)) ? pin_mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] bus_value(input logic drv, input logic [15:0] dqo,
      input logic ce_n, input logic we_n, input logic oe_n,
      input logic [1:0] be_n, input logic [15:0] a);
    logic [15:0] v;
    logic [15:0] m;
    m = pin_rd(a);
    for (int l = 0; l < 2; l++) begin
      if (drv) v[l*8 +: 8] = dqo[l*8 +: 8];
      else if (!ce_n && we_n && !oe_n && !be_n[l]) v[l*8 +: 8] = m[l*8 +: 8];
      else v[l*8 +: 8] = 8'hzz;
    end
    return v;
  endfunction

  assign mem_dq_i = bus_value(mem_dq_oe, mem_dq_o, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Memory model: stores enabled lanes while strobe low; flags contention.
  always @(negedge clk) begin
    if (rst_n) begin
      logic drives;
      logic [15:0] w;
      drives = !mem_ce_n && !mem_oe_n && mem_we_n && !(&mem_be_n);
      chk(!(mem_dq_oe && drives), "R6 contention", {31'd0, mem_dq_oe}, 32'd0);
      if (!mem_ce_n && !mem_we_n) begin
        w = pin_rd(mem_addr);
        for (int l = 0; l < 2; l++)
          if (!mem_be_n[l]) w[l*8 +: 8] = mem_dq_oe ? mem_dq_o[l*8 +: 8] : 8'hxx;
        pin_mem[int'(mem_addr)] = w;
      end
    end
  end

  // Reference model, advanced on each rising edge from the request inputs.
  int          m_phase = M_IDLE;
  int          m_cnt   = 0;
  logic [15:0] m_addr  = '0;
  logic [15:0] m_data  = '0;
  logic [1:0]  m_mask  = '0;
  logic        e_rsp   = 1'b0;
  logic [15:0] e_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = M_IDLE;
      e_rsp   = 1'b0;
    end else begin
      e_rsp = 1'b0;
      case (m_phase)
        M_IDLE: if (req_valid) begin
          m_addr = req_addr; m_data = req_wdata; m_mask = req_mask;
          m_phase = req_write ? M_WS : M_RS;
        end
        M_WS: begin m_phase = M_WP; m_cnt = EXP_WAIT; end
        M_WP: begin
          m_cnt--;
          if (m_cnt == 0) begin
            logic [15:0] w;
            w = ref_rd(m_addr);
            if (m_mask[0]) w[7:0]  = m_data[7:0];
            if (m_mask[1]) w[15:8] = m_data[15:8];
            ref_mem[int'(m_addr)] = w;
            m_phase = M_WH;
          end
        end
        M_WH: m_phase = M_IDLE;
        M_RS: begin m_phase = M_RA; m_cnt = EXP_WAIT; end
        M_RA: begin
          m_cnt--;
          if (m_cnt == 0) begin
            logic [15:0] r;
            r = ref_rd(m_addr);
            e_rdata = {m_mask[1] ? r[15:8] : 8'h00, m_mask[0] ? r[7:0] : 8'h00};
            e_rsp = 1'b1;
            m_phase = M_IDLE;
          end
        end
        default: m_phase = M_IDLE;
      endcase
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  int we_run = 0;
  int oe_run = 0;

  always @(negedge clk) begin
    logic e_ce, e_we, e_oe, e_rdy, e_drv;
    logic [1:0] e_be;
    e_ce = (m_phase == M_IDLE);
    e_we = (m_phase != M_WP);
    e_oe = (m_phase != M_RA);
    e_rdy = (m_phase == M_IDLE);
    e_drv = (m_phase == M_WP);
    e_be = (m_phase == M_IDLE) ? 2'b11 : ~m_mask;
    if (!rst_n) begin
      // R1: reset state
      chk(mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 reset idle", {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 32'h3e);
    end else begin
      chk(mem_ce_n === e_ce, "R1 R2 ce_n", {31'd0, mem_ce_n}, {31'd0, e_ce});
      chk(mem_we_n === e_we, "R2 we_n", {31'd0, mem_we_n}, {31'd0, e_we});
      chk(mem_oe_n === e_oe, "R4 oe_n", {31'd0, mem_oe_n}, {31'd0, e_oe});
      chk(mem_be_n === e_be, "R3 be_n", {30'd0, mem_be_n}, {30'd0, e_be});
      chk(req_ready === e_rdy, "R9 ready", {31'd0, req_ready}, {31'd0, e_rdy});
      chk(mem_dq_oe === e_drv, "R5 dq_oe", {31'd0, mem_dq_oe}, {31'd0, e_drv});
      if (e_drv) chk(mem_dq_o === m_data, "R5 dq_o", {16'd0, mem_dq_o}, {16'd0, m_data});
      if (!e_ce) chk(mem_addr === m_addr, "R11 addr", {16'd0, mem_addr}, {16'd0, m_addr});
      chk(rsp_valid === e_rsp, "R7 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rsp});
      if (e_rsp) chk(rsp_rdata === e_rdata, "R7 R8 rdata", {16'd0, rsp_rdata}, {16'd0, e_rdata});
      // R10: length of each strobe and sample phase
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin chk(we_run == EXP_WAIT, "R10 we width", we_run, EXP_WAIT); we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin chk(oe_run == EXP_WAIT, "R10 oe width", oe_run, EXP_WAIT); oe_run = 0; end
    end
  end

  // Holds valid through any busy period, drops it after acceptance (R9).
  task automatic send(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 16'hdead;
    req_addr  = ~a;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R8: full write, then single-lane merges, each read straight after
    send(1, 16'h1234, 16'hBEEF, 2'b11);
    send(0, 16'h1234, 16'h0000, 2'b11);
    send(1, 16'h1234, 16'h5512, 2'b01);
    send(0, 16'h1234, 16'h0000, 2'b11);
    send(1, 16'h1234, 16'h7799, 2'b10);
    send(0, 16'h1234, 16'h0000, 2'b11);
    // R7: partial-lane reads return zero in the other lane
    send(0, 16'h1234, 16'h0000, 2'b01);
    send(0, 16'h1234, 16'h0000, 2'b10);
    send(0, 16'h1234, 16'h0000, 2'b00);
    // R3: write with empty mask changes nothing
    send(1, 16'h1234, 16'h0000, 2'b00);
    send(0, 16'h1234, 16'h0000, 2'b11);
    // address extremes
    send(1, 16'h0000, 16'hA5C3, 2'b11);
    send(1, 16'hFFFF, 16'h3C5A, 2'b11);
    send(0, 16'h0000, 16'h0000, 2'b11);
    send(0, 16'hFFFF, 16'h0000, 2'b11);
    // computed mixed sequence over a small address set
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[3], {12'h0F0, lfsr[7:4]}, lfsr[23:8], lfsr[25:24]);
    end
    repeat (12) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule